// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block runs a small 8-bit core's low-power state. A one-cycle sleep strobe from the core stops the oscillator, pulses the watchdog-clear line and updates two status flags. From then on the block watches three things on a slow clock that is always running. The first is an active-low external reset input. The second is a watchdog time-out pulse, which counts only when the watchdog is enabled. The third is a group of wake-capable input pins. Every wake ends in a device-reset request, never in resumed execution. The cause is recorded in status flags that the reset request itself does not clear.

The pins pass through a synchronizer and are then compared with a snapshot. The core refreshes that snapshot with a port-read strobe, not by sampling on every clock. If the pins have moved since the last read, entering sleep wakes the core again at once. Software must therefore read the port just before it sleeps.

Top module: `doze_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, the outputs are: `osc_en`=1, `flag_to`=1, `flag_pd`=1, `flag_pcw`=0, `dev_rst`=0 and `wdt_clr`=0. The pin snapshot is all zeros.
- R2: A `sleep_req` sampled high while awake, with no reset event in the same cycle, puts the block to sleep at that edge. After the edge, `osc_en`=0, `flag_pd`=0, `flag_to`=1 and `flag_pcw`=0, and `wdt_clr` is high for exactly one cycle.
- R3: While asleep, `ext_rst_n` sampled low wakes the block at that edge. `dev_rst` and `wdt_clr` then go high for one cycle and `osc_en` returns to 1. `flag_to` stays 1 and `flag_pd` stays 0.
- R4: While asleep, `wdt_tmo` sampled high with `wdt_en`=1 wakes the block in the same way as R3, and `flag_to` becomes 0. With `wdt_en`=0, `wdt_tmo` has no effect.
- R5: While asleep, the block wakes with `flag_pcw`=1 once the synchronized pins differ from the snapshot. A pin change made between edges shows `dev_rst` after the third following rising edge.
- R6: The snapshot is loaded from the synchronized pins only when `port_rd` is high while awake. If the snapshot differs from the pins when sleep is entered, the block wakes one cycle after entry.
- R7: While asleep, `sleep_req` and `port_rd` are ignored. No extra `wdt_clr` pulse is produced, the flags do not change, and the snapshot is not updated.
- R8: When several wake events fall in the same cycle, external reset wins over watchdog, and watchdog wins over pin change. `flag_to` is cleared only when the watchdog wins. `flag_pcw` is set at any wake where a pin mismatch exists.
- R9: While awake, an external reset or an enabled watchdog time-out raises `dev_rst` and `wdt_clr` while `osc_en` stays 1. Either event also cancels a `sleep_req` in the same cycle. A watchdog time-out additionally sets `flag_to`=0 and `flag_pd`=1. An external reset leaves the flags unchanged.
- R10: `dev_rst` is never high while `osc_en` is 0. While asleep with no wake event, `dev_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow, always-on clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe from the core |
| ext_rst_n | input | 1 | External reset input, active low, already synchronous |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tmo | input | 1 | Watchdog time-out pulse |
| wake_pins | input | NPINS | Wake-capable input pins (asynchronous) |
| port_rd | input | 1 | Port read or bit-operation strobe; loads the snapshot |
| osc_en | output | 1 | Oscillator enable, low while asleep |
| wdt_clr | output | 1 | One-cycle watchdog-clear pulse |
| dev_rst | output | 1 | Device-reset request, separate from the external reset input |
| flag_to | output | 1 | Time-out flag, 0 after a watchdog reset |
| flag_pd | output | 1 | Power-down flag, 0 after sleep entry |
| flag_pcw | output | 1 | Pin-change wake flag |

## Verification
Most wrong internal states show at the ports within one edge. A bad state register shows through `osc_en` straight away. A missed or extra wake shows in `dev_rst` on the cycle after the triggering sample. A wrong cause decode shows as a wrong `flag_to` or `flag_pcw` in that same cycle.

A corrupt snapshot is the slow case. Nothing shows until the next sleep entry, which then either wakes one cycle later for no pin activity or fails to wake. For that reason, the tests run sleep entries both with matched snapshots and with stale ones.

// File: rtl/doze_pkg.sv
// Shared types for the sleep and wake-up controller.
package doze_pkg;

    // Run state of the core as seen by this block.
    typedef enum logic {
        ST_AWAKE  = 1'b0,
        ST_ASLEEP = 1'b1
    } doze_state_e;

    // Winning wake/reset cause for the current cycle.
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_EXT  = 2'd1,
        WK_WDT  = 2'd2,
        WK_PIN  = 2'd3
    } wake_cause_e;

endpackage

// File: rtl/doze_pin_sync.sv
// Multi-stage synchronizer for the wake-capable pins.
// Assumes: pins are asynchronous to clk, and a pin change needs no
// glitch filter beyond the synchronizer. Output lags input by STAGES edges.
module doze_pin_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the pin vector through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/doze_change_det.sv
// Holds the snapshot of the pins taken at the last port read and flags
// any difference between it and the current synchronized pins.
// Assumes: capture is already gated to the awake state by the caller.
module doze_change_det #(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] pins_s,
    output logic             mismatch
);
    logic [WIDTH-1:0] snap_q;

    // Load the reference snapshot on a port read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture) begin
            snap_q <= pins_s;
        end
    end

    // Any differing bit counts as a change.
    always_comb begin
        mismatch = |(pins_s ^ snap_q);
    end
endmodule

// File: rtl/doze_cause_arb.sv
// Fixed-priority pick of the wake/reset cause: external reset, then
// watchdog, then pin change. Pin change counts only while asleep.
module doze_cause_arb
    import doze_pkg::*;
(
    input  logic        asleep,
    input  logic        ext_evt,
    input  logic        wdt_evt,
    input  logic        mismatch,
    output wake_cause_e cause
);
    // Priority encode the event set into one cause.
    always_comb begin
        if (ext_evt)                cause = WK_EXT;
        else if (wdt_evt)           cause = WK_WDT;
        else if (asleep && mismatch) cause = WK_PIN;
        else                        cause = WK_NONE;
    end
endmodule

// File: rtl/doze_fsm.sv
// Sleep state machine and status flags. All outputs are registered.
// Assumes: at most one sleep_req strobe per instruction. The flags are
// cleared only by power-on reset or by the events described here, never
// by dev_rst.
module doze_fsm
    import doze_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_req,
    input  logic        mismatch,
    input  wake_cause_e cause,
    output logic        asleep,
    output logic        dev_rst,
    output logic        wdt_clr,
    output logic        flag_to,
    output logic        flag_pd,
    output logic        flag_pcw
);
    doze_state_e st_q, st_d;
    logic        to_q, to_d, pd_q, pd_d, pcw_q, pcw_d;
    logic        rst_q, rst_d, clr_q, clr_d;

    // Next-state and flag update for one cycle.
    always_comb begin
        st_d  = st_q;
        to_d  = to_q;
        pd_d  = pd_q;
        pcw_d = pcw_q;
        rst_d = 1'b0;
        clr_d = 1'b0;
        unique case (st_q)
            ST_AWAKE: begin
                if (cause == WK_EXT) begin
                    rst_d = 1'b1;
                    clr_d = 1'b1;
                end else if (cause == WK_WDT) begin
                    rst_d = 1'b1;
                    clr_d = 1'b1;
                    to_d  = 1'b0;
                    pd_d  = 1'b1;
                end else if (sleep_req) begin
                    st_d  = ST_ASLEEP;
                    clr_d = 1'b1;
                    to_d  = 1'b1;
                    pd_d  = 1'b0;
                    pcw_d = 1'b0;
                end
            end
            ST_ASLEEP: begin
                if (cause != WK_NONE) begin
                    st_d  = ST_AWAKE;
                    rst_d = 1'b1;
                    clr_d = 1'b1;
                    if (cause == WK_WDT) to_d = 1'b0;
                    if (mismatch)        pcw_d = 1'b1;
                end
            end
            default: st_d = ST_AWAKE;
        endcase
    end

    // State, flag and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_AWAKE;
            to_q  <= 1'b1;
            pd_q  <= 1'b1;
            pcw_q <= 1'b0;
            rst_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            to_q  <= to_d;
            pd_q  <= pd_d;
            pcw_q <= pcw_d;
            rst_q <= rst_d;
            clr_q <= clr_d;
        end
    end

    assign asleep   = (st_q == ST_ASLEEP);
    assign dev_rst  = rst_q;
    assign wdt_clr  = clr_q;
    assign flag_to  = to_q;
    assign flag_pd  = pd_q;
    assign flag_pcw = pcw_q;
endmodule

// File: rtl/doze_wake_ctrl.sv
// Top of the sleep and wake-up controller. It synchronizes the wake
// pins, compares them with the last port-read snapshot, arbitrates the
// wake causes and runs the sleep state machine.
// Assumes: clk runs during sleep, and ext_rst_n is synchronous to clk.
module doze_wake_ctrl #(
    parameter int unsigned NPINS       = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             ext_rst_n,
    input  logic             wdt_en,
    input  logic             wdt_tmo,
    input  logic [NPINS-1:0] wake_pins,
    input  logic             port_rd,
    output logic             osc_en,
    output logic             wdt_clr,
    output logic             dev_rst,
    output logic             flag_to,
    output logic             flag_pd,
    output logic             flag_pcw
);
    import doze_pkg::*;

    logic [NPINS-1:0] pins_s;
    logic             mismatch;
    logic             asleep;
    logic             ext_evt, wdt_evt;
    wake_cause_e      cause;

    // Event qualification from the raw strobes.
    always_comb begin
        ext_evt = !ext_rst_n;
        wdt_evt = wdt_en && wdt_tmo;
    end

    doze_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (wake_pins),
        .dout  (pins_s)
    );

    doze_change_det #(.WIDTH(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (port_rd && !asleep),
        .pins_s   (pins_s),
        .mismatch (mismatch)
    );

    doze_cause_arb u_arb (
        .asleep   (asleep),
        .ext_evt  (ext_evt),
        .wdt_evt  (wdt_evt),
        .mismatch (mismatch),
        .cause    (cause)
    );

    doze_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .mismatch  (mismatch),
        .cause     (cause),
        .asleep    (asleep),
        .dev_rst   (dev_rst),
        .wdt_clr   (wdt_clr),
        .flag_to   (flag_to),
        .flag_pd   (flag_pd),
        .flag_pcw  (flag_pcw)
    );

    assign osc_en = !asleep;
endmodule

// File: rtl/doze_wake_ctrl_chk.sv
// Port-level property checker for doze_wake_ctrl, attached by bind.
module doze_wake_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic ext_rst_n,
    input logic wdt_en,
    input logic wdt_tmo,
    input logic osc_en,
    input logic wdt_clr,
    input logic dev_rst,
    input logic flag_to,
    input logic flag_pd,
    input logic flag_pcw
);
    // R2: a clean sleep request while awake enters sleep.
    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en && sleep_req && ext_rst_n && !(wdt_en && wdt_tmo)
        |=> !osc_en && !flag_pd && flag_to && !flag_pcw && wdt_clr);

    // R2: the power-down flag falls only on entry to sleep.
    p_pd_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_pd) |-> !osc_en);

    // R3 and R8: external reset during sleep wakes and keeps the time-out flag.
    p_ext_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en && !ext_rst_n |=> osc_en && dev_rst && wdt_clr && flag_to);

    // R4: an enabled watchdog time-out during sleep wakes and clears the time-out flag.
    p_wdt_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en && ext_rst_n && wdt_en && wdt_tmo |=> osc_en && dev_rst && !flag_to);

    // R5: the pin-change flag rises only together with a wake reset.
    p_pcw_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_pcw) |-> dev_rst);

    // R9: a watchdog time-out while awake resets without sleeping.
    p_awake_wdt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en && ext_rst_n && wdt_en && wdt_tmo
        |=> osc_en && dev_rst && !flag_to && flag_pd);

    // R10: a reset request always comes with the oscillator on and a watchdog clear.
    p_rst_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |-> osc_en && wdt_clr);
endmodule

bind doze_wake_ctrl doze_wake_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .ext_rst_n (ext_rst_n),
    .wdt_en    (wdt_en),
    .wdt_tmo   (wdt_tmo),
    .osc_en    (osc_en),
    .wdt_clr   (wdt_clr),
    .dev_rst   (dev_rst),
    .flag_to   (flag_to),
    .flag_pd   (flag_pd),
    .flag_pcw  (flag_pcw)
);

// File: tb/doze_wake_ctrl_test.sv
// Directed bench for doze_wake_ctrl. It drives and samples on falling edges.
module doze_wake_ctrl_test;
    localparam int NPINS = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic             ext_rst_n = 1'b1;
    logic             wdt_en = 1'b0;
    logic             wdt_tmo = 1'b0;
    logic [NPINS-1:0] wake_pins = '0;
    logic             port_rd = 1'b0;
    logic             osc_en, wdt_clr, dev_rst, flag_to, flag_pd, flag_pcw;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    doze_wake_ctrl #(.NPINS(NPINS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .ext_rst_n (ext_rst_n),
        .wdt_en    (wdt_en),
        .wdt_tmo   (wdt_tmo),
        .wake_pins (wake_pins),
        .port_rd   (port_rd),
        .osc_en    (osc_en),
        .wdt_clr   (wdt_clr),
        .dev_rst   (dev_rst),
        .flag_to   (flag_to),
        .flag_pd   (flag_pd),
        .flag_pcw  (flag_pcw)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
    endtask

    task automatic read_port();
        port_rd = 1'b1;
        tick();
        port_rd = 1'b0;
    endtask

    task automatic ext_wake();
        ext_rst_n = 1'b0;
        tick();
        ext_rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        chk("R1", "osc_en", osc_en, 1'b1);
        chk("R1", "flag_to", flag_to, 1'b1);
        chk("R1", "flag_pd", flag_pd, 1'b1);
        chk("R1", "flag_pcw", flag_pcw, 1'b0);
        chk("R1", "dev_rst", dev_rst, 1'b0);
        chk("R1", "wdt_clr", wdt_clr, 1'b0);
    endtask

    task automatic t_sleep_entry();
        read_port();
        go_sleep();
        chk("R2", "osc_en", osc_en, 1'b0);
        chk("R2", "flag_pd", flag_pd, 1'b0);
        chk("R2", "flag_to", flag_to, 1'b1);
        chk("R2", "wdt_clr", wdt_clr, 1'b1);
        tick();
        chk("R2", "wdt_clr one cycle", wdt_clr, 1'b0);
        chk("R10", "no dev_rst idle asleep", dev_rst, 1'b0);
        chk("R10", "still asleep", osc_en, 1'b0);
    endtask

    task automatic t_ext_wake();
        ext_rst_n = 1'b0;
        tick();
        ext_rst_n = 1'b1;
        chk("R3", "dev_rst", dev_rst, 1'b1);
        chk("R3", "osc_en", osc_en, 1'b1);
        chk("R3", "wdt_clr", wdt_clr, 1'b1);
        chk("R3", "flag_to", flag_to, 1'b1);
        chk("R3", "flag_pd", flag_pd, 1'b0);
        tick();
        chk("R3", "dev_rst one cycle", dev_rst, 1'b0);
    endtask

    task automatic t_wdt_wake();
        go_sleep();
        wdt_en = 1'b0;
        wdt_tmo = 1'b1;
        tick();
        wdt_tmo = 1'b0;
        chk("R4", "disabled tmo ignored osc", osc_en, 1'b0);
        chk("R4", "disabled tmo ignored rst", dev_rst, 1'b0);
        wdt_en = 1'b1;
        wdt_tmo = 1'b1;
        tick();
        wdt_tmo = 1'b0;
        chk("R4", "dev_rst", dev_rst, 1'b1);
        chk("R4", "flag_to", flag_to, 1'b0);
        chk("R4", "osc_en", osc_en, 1'b1);
        wdt_en = 1'b0;
        tick();
    endtask

    task automatic t_pin_wake();
        go_sleep();
        wake_pins = 3'b001;
        tick();
        tick();
        chk("R5", "asleep before sync settles", osc_en, 1'b0);
        tick();
        chk("R5", "dev_rst", dev_rst, 1'b1);
        chk("R5", "flag_pcw", flag_pcw, 1'b1);
        chk("R5", "flag_to", flag_to, 1'b1);
        tick();
    endtask

    task automatic t_stale();
        tick();
        tick();
        go_sleep();
        chk("R6", "entered sleep", osc_en, 1'b0);
        chk("R6", "pcw cleared on entry", flag_pcw, 1'b0);
        tick();
        chk("R6", "immediate wake", dev_rst, 1'b1);
        chk("R6", "flag_pcw", flag_pcw, 1'b1);
        tick();
    endtask

    task automatic t_ignored();
        go_sleep();
        port_rd = 1'b1;
        sleep_req = 1'b1;
        tick();
        port_rd = 1'b0;
        sleep_req = 1'b0;
        chk("R7", "port_rd asleep left snapshot stale", dev_rst, 1'b1);
        chk("R7", "pcw after stale wake", flag_pcw, 1'b1);
        tick();
        read_port();
        go_sleep();
        tick();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
        chk("R7", "no wdt_clr from sleep_req asleep", wdt_clr, 1'b0);
        chk("R7", "still asleep", osc_en, 1'b0);
        chk("R7", "flag_pd", flag_pd, 1'b0);
        ext_wake();
    endtask

    task automatic t_priority();
        go_sleep();
        ext_rst_n = 1'b0;
        wdt_en = 1'b1;
        wdt_tmo = 1'b1;
        tick();
        ext_rst_n = 1'b1;
        wdt_tmo = 1'b0;
        chk("R8", "ext over wdt dev_rst", dev_rst, 1'b1);
        chk("R8", "ext over wdt keeps to", flag_to, 1'b1);
        tick();
        wake_pins = 3'b000;
        tick();
        tick();
        go_sleep();
        wdt_tmo = 1'b1;
        tick();
        wdt_tmo = 1'b0;
        chk("R8", "wdt over pin dev_rst", dev_rst, 1'b1);
        chk("R8", "wdt over pin clears to", flag_to, 1'b0);
        chk("R8", "pcw set with mismatch", flag_pcw, 1'b1);
        wdt_en = 1'b0;
        tick();
        read_port();
    endtask

    task automatic t_awake();
        wdt_en = 1'b1;
        wdt_tmo = 1'b1;
        tick();
        wdt_tmo = 1'b0;
        wdt_en = 1'b0;
        chk("R9", "wdt awake dev_rst", dev_rst, 1'b1);
        chk("R9", "wdt awake osc_en", osc_en, 1'b1);
        chk("R9", "wdt awake flag_to", flag_to, 1'b0);
        chk("R9", "wdt awake flag_pd", flag_pd, 1'b1);
        tick();
        ext_rst_n = 1'b0;
        sleep_req = 1'b1;
        tick();
        ext_rst_n = 1'b1;
        sleep_req = 1'b0;
        chk("R9", "ext awake dev_rst", dev_rst, 1'b1);
        chk("R9", "sleep cancelled", osc_en, 1'b1);
        chk("R9", "ext awake flag_pd kept", flag_pd, 1'b1);
        chk("R9", "ext awake flag_to kept", flag_to, 1'b0);
        tick();
        chk("R9", "dev_rst released", dev_rst, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        tick();
        tick();
        chk("R1", "osc_en in reset", osc_en, 1'b1);
        chk("R1", "dev_rst in reset", dev_rst, 1'b0);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sleep_entry();
        t_ext_wake();
        t_wdt_wake();
        t_pin_wake();
        t_stale();
        t_ignored();
        t_priority();
        t_awake();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule